// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block translates request addresses for a PCIe root complex through a small set of programmable windows. There are four outbound and four inbound windows. Software reaches them through one shared set of per-window registers. A selector register picks the direction and the window index, and the shared registers then address that window. Each window holds a base, a 32-bit limit, a target and two control words. The first control word gives the transaction kind. The second control word holds the enable bit, and a write to it decides when the window takes effect.

Each lookup names a direction and an address. The unit searches the enabled windows of that direction. If the address falls in one of them, it returns the address moved into the target space (target plus the offset from the base), the window's kind and a hit flag. For configuration-kind windows it also returns the bus number and the device/function number carried in the target. The result is registered and appears one clock after the request. Out of reset, inbound window 0 is already an enabled memory window that passes the low 4 GiB through unchanged.

Top module: `vpx_xlate`

## Requirements
- R1: A write at offset 0x900 stores a direction bit (bit 31: 1 = inbound, 0 = outbound) and a window index (bits 3:0). A read at 0x900 returns only those fields, with every other bit zero.
- R2: For the selected window, offsets 0x904 (control 1), 0x908 (control 2), 0x90C (base low), 0x910 (base high), 0x914 (limit), 0x918 (target low) and 0x91C (target high) are written and read back as full 32-bit words. Bit 30 of control 2 is stored and has no effect on lookups. Any other offset reads zero.
- R3: While the selected index is 4 or more, reads of offsets 0x904 to 0x91C return zero and writes to them are dropped.
- R4: Writes to base, limit, target and control 1 are staged and do not change lookups. A write to control 2 with bit 31 set commits the staged values. A write to control 2 with bit 31 clear disables the window. A lookup in the same cycle as a commit uses the state from before the commit.
- R5: An enabled window hits when base <= address <= {base[63:32], limit}. The translated address is target + (address - base). The result appears on the clock edge after the request.
- R6: When several windows of one direction hit, the lowest-numbered one supplies the result.
- R7: A lookup that hits nothing returns hit 0, the request address unchanged, kind 0, bus 0 and device/function 0.
- R8: Control 1 bits 4:0 give the kind: 0 memory, 2 I/O, 4 configuration type 0, 5 configuration type 1. For a configuration-kind hit, bus = target[31:24] and device/function = target[23:16]. Otherwise both are zero.
- R9: Inbound windows of configuration kind never hit.
- R10: After reset, inbound window 0 is enabled, of memory kind, with base 0, limit 0xFFFFFFFF and target 0. Its control 2 reads 0x80000000 and its limit reads 0xFFFFFFFF. Every other register reads zero.
- R11: Outbound lookups consult only outbound windows, and inbound lookups consult only inbound windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| lk_req | input | 1 | Lookup request |
| lk_inbound | input | 1 | Lookup direction, 1 = inbound |
| lk_addr | input | 64 | Address to translate |
| res_valid | output | 1 | Result valid, one cycle after lk_req |
| res_hit | output | 1 | A window matched |
| res_addr | output | 64 | Translated address, or the request address on a miss |
| res_kind | output | 5 | Kind of the matching window |
| res_bus | output | 8 | Bus number for configuration hits |
| res_devfn | output | 8 | Device/function number for configuration hits |

## Verification
The bench probes both edges of each window: the base, the last address allowed by the limit, one address past the limit and one address below the base. An off-by-one in either comparator turns one of those into a wrong hit or a wrong miss. It changes a committed window's staged target and looks it up before and after the commit. A design that forwarded staged values directly would show the new target too early. Overlapping windows are disabled one at a time to expose a wrong priority order. The bench also disables the default inbound window so that an inbound configuration window is the only candidate; a design that failed to filter it would report a hit. Finally, writes made while an out-of-range index is selected are checked against the real windows, which must stay unchanged.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
   localparam int unsigned ADDR_W = 64;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned KIND_W = 5;
   localparam int unsigned OFS_W  = 12;
   localparam int unsigned VIDX_W = 4;
   localparam int unsigned CFGID_W = 16;

   localparam int unsigned DIR_BIT = 31;
   localparam int unsigned ENA_BIT = 31;
   localparam int unsigned BARM_BIT = 30;
   localparam int unsigned CFGID_LSB = 16;

   localparam logic [OFS_W-1:0] OFS_VIEW = 12'h900;
   localparam logic [OFS_W-1:0] OFS_CTL1 = 12'h904;
   localparam logic [OFS_W-1:0] OFS_CTL2 = 12'h908;
   localparam logic [OFS_W-1:0] OFS_BLO  = 12'h90C;
   localparam logic [OFS_W-1:0] OFS_BHI  = 12'h910;
   localparam logic [OFS_W-1:0] OFS_LIM  = 12'h914;
   localparam logic [OFS_W-1:0] OFS_TLO  = 12'h918;
   localparam logic [OFS_W-1:0] OFS_THI  = 12'h91C;

   localparam logic [KIND_W-1:0] KIND_MEM  = 5'd0;
   localparam logic [KIND_W-1:0] KIND_IO   = 5'd2;
   localparam logic [KIND_W-1:0] KIND_CFG0 = 5'd4;
   localparam logic [KIND_W-1:0] KIND_CFG1 = 5'd5;

   // software-visible staged copy of one window
   typedef struct packed {
      logic [WORD_W-1:0] ctl1;
      logic [WORD_W-1:0] ctl2;
      logic [ADDR_W-1:0] base;
      logic [WORD_W-1:0] lim;
      logic [ADDR_W-1:0] tgt;
   } stage_t;

   // committed copy, pre-digested for the lookup path
   typedef struct packed {
      logic               en;
      logic [KIND_W-1:0]  kind;
      logic [ADDR_W-1:0]  base;
      logic [ADDR_W-1:0]  top;
      logic [ADDR_W-1:0]  delta;
      logic [CFGID_W-1:0] cfg_id;
   } win_t;

   function automatic logic kind_is_cfg(input logic [KIND_W-1:0] k);
      return (k == KIND_CFG0) || (k == KIND_CFG1);
   endfunction
endpackage

// File: rtl/vpx_slot.sv
module vpx_slot
   import vpx_pkg::*;
#(
   parameter bit PASS_DEFAULT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr_en,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [WORD_W-1:0] wdata,
   output stage_t            stg,
   output win_t              act
);
   localparam logic [WORD_W-1:0] LIM_RST  = PASS_DEFAULT ? {WORD_W{1'b1}} : '0;
   localparam logic [WORD_W-1:0] CTL2_RST = PASS_DEFAULT ? (WORD_W'(1) << ENA_BIT) : '0;

   stage_t stg_q;
   win_t   act_q;
   logic   wr_hit;

   assign wr_hit = sel && wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q.ctl1 <= '0;
         stg_q.ctl2 <= CTL2_RST;
         stg_q.base <= '0;
         stg_q.lim  <= LIM_RST;
         stg_q.tgt  <= '0;
      end else if (wr_hit) begin
         case (ofs)
            OFS_CTL1: stg_q.ctl1 <= wdata;
            OFS_CTL2: stg_q.ctl2 <= wdata;
            OFS_BLO:  stg_q.base[WORD_W-1:0] <= wdata;
            OFS_BHI:  stg_q.base[ADDR_W-1:WORD_W] <= wdata;
            OFS_LIM:  stg_q.lim <= wdata;
            OFS_TLO:  stg_q.tgt[WORD_W-1:0] <= wdata;
            OFS_THI:  stg_q.tgt[ADDR_W-1:WORD_W] <= wdata;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q.en     <= PASS_DEFAULT;
         act_q.kind   <= KIND_MEM;
         act_q.base   <= '0;
         act_q.top    <= {{(ADDR_W-WORD_W){1'b0}}, LIM_RST};
         act_q.delta  <= '0;
         act_q.cfg_id <= '0;
      end else if (wr_hit && (ofs == OFS_CTL2)) begin
         if (wdata[ENA_BIT]) begin
            act_q.en     <= 1'b1;
            act_q.kind   <= stg_q.ctl1[KIND_W-1:0];
            act_q.base   <= stg_q.base;
            act_q.top    <= {stg_q.base[ADDR_W-1:WORD_W], stg_q.lim};
            act_q.delta  <= stg_q.tgt - stg_q.base;
            act_q.cfg_id <= stg_q.tgt[CFGID_LSB +: CFGID_W];
         end else begin
            act_q.en <= 1'b0;
         end
      end
   end

   assign stg = stg_q;
   assign act = act_q;

   // R4
   stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && (ofs != OFS_CTL2)) |=> $stable(act_q));

   // R4
   commit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && (ofs == OFS_CTL2) && wdata[ENA_BIT])
      |=> (act_q.en && (act_q.base == $past(stg_q.base))));

   // R3
   unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(stg_q));
endmodule

// File: rtl/vpx_regfile.sv
module vpx_regfile
   import vpx_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFS_W-1:0]  addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   output win_t              act_out [2*NUM_WIN]
);
   localparam int unsigned NSLOT = 2 * NUM_WIN;
   localparam int unsigned PAD_W = WORD_W - 1 - VIDX_W;

   logic              vp_dir_q;
   logic [VIDX_W-1:0] vp_idx_q;
   logic              idx_ok;
   stage_t            stg_arr [NSLOT];
   stage_t            cur;

   assign idx_ok = int'(vp_idx_q) < int'(NUM_WIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vp_dir_q <= 1'b0;
         vp_idx_q <= '0;
      end else if (wr_en && (addr == OFS_VIEW)) begin
         vp_dir_q <= wdata[DIR_BIT];
         vp_idx_q <= wdata[VIDX_W-1:0];
      end
   end

   for (genvar d = 0; d < 2; d++) begin : g_dir
      for (genvar i = 0; i < int'(NUM_WIN); i++) begin : g_win
         localparam int SLOT = d * int'(NUM_WIN) + i;
         logic sel_w;
         assign sel_w = idx_ok && (vp_dir_q == 1'(d)) && (int'(vp_idx_q) == i);
         vpx_slot #(
            .PASS_DEFAULT((d == 1) && (i == 0))
         ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel_w),
            .wr_en (wr_en),
            .ofs   (addr),
            .wdata (wdata),
            .stg   (stg_arr[SLOT]),
            .act   (act_out[SLOT])
         );
      end
   end

   always_comb begin
      cur = '0;
      for (int s = 0; s < int'(NSLOT); s++) begin
         if (idx_ok && (s == int'(vp_dir_q) * int'(NUM_WIN) + int'(vp_idx_q))) cur = stg_arr[s];
      end
      case (addr)
         OFS_VIEW: rdata = {vp_dir_q, {PAD_W{1'b0}}, vp_idx_q};
         OFS_CTL1: rdata = cur.ctl1;
         OFS_CTL2: rdata = cur.ctl2;
         OFS_BLO:  rdata = cur.base[WORD_W-1:0];
         OFS_BHI:  rdata = cur.base[ADDR_W-1:WORD_W];
         OFS_LIM:  rdata = cur.lim;
         OFS_TLO:  rdata = cur.tgt[WORD_W-1:0];
         OFS_THI:  rdata = cur.tgt[ADDR_W-1:WORD_W];
         default:  rdata = '0;
      endcase
   end

   // R1
   view_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == OFS_VIEW) |-> (rdata[DIR_BIT-1:VIDX_W] == '0));
endmodule

// File: rtl/vpx_lookup.sv
module vpx_lookup
   import vpx_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4,
   parameter bit          INBOUND = 1'b0
) (
   input  win_t               wins [NUM_WIN],
   input  logic [ADDR_W-1:0]  addr,
   output logic               hit,
   output logic [ADDR_W-1:0]  xaddr,
   output logic [KIND_W-1:0]  kind,
   output logic [7:0]         bus,
   output logic [7:0]         devfn
);
   logic [NUM_WIN-1:0] cand;
   logic [NUM_WIN-1:0] grant;
   win_t               pick;
   logic               cfg_hit;

   for (genvar i = 0; i < int'(NUM_WIN); i++) begin : g_cmp
      logic kind_ok;
      if (INBOUND) begin : g_inb
         assign kind_ok = !kind_is_cfg(wins[i].kind);
      end else begin : g_outb
         assign kind_ok = 1'b1;
      end
      assign cand[i] = wins[i].en && kind_ok &&
                       (addr >= wins[i].base) && (addr <= wins[i].top);
   end

   // isolate the lowest set candidate
   assign grant = cand & (~cand + NUM_WIN'(1));

   always_comb begin
      pick = '0;
      for (int i = 0; i < int'(NUM_WIN); i++) begin
         if (grant[i]) pick = wins[i];
      end
      hit     = |cand;
      xaddr   = hit ? (addr + pick.delta) : addr;
      kind    = hit ? pick.kind : KIND_MEM;
      cfg_hit = hit && kind_is_cfg(pick.kind);
      bus     = cfg_hit ? pick.cfg_id[CFGID_W-1:8] : '0;
      devfn   = cfg_hit ? pick.cfg_id[7:0] : '0;
   end
endmodule

// File: rtl/vpx_xlate.sv
module vpx_xlate
   import vpx_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              lk_req,
   input  logic              lk_inbound,
   input  logic [63:0]       lk_addr,
   output logic              res_valid,
   output logic              res_hit,
   output logic [63:0]       res_addr,
   output logic [4:0]        res_kind,
   output logic [7:0]        res_bus,
   output logic [7:0]        res_devfn
);
   localparam int unsigned MAX_WIN = 1 << VIDX_W;

   if ((NUM_WIN < 1) || (NUM_WIN > MAX_WIN)) begin : g_bad_cfg
      $error("vpx_xlate: NUM_WIN out of range");
   end

   win_t acts     [2*NUM_WIN];
   win_t out_wins [NUM_WIN];
   win_t in_wins  [NUM_WIN];

   logic              o_hit, i_hit;
   logic [ADDR_W-1:0] o_addr, i_addr;
   logic [KIND_W-1:0] o_kind, i_kind;
   logic [7:0]        o_bus, i_bus, o_dfn, i_dfn;

   vpx_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .act_out (acts)
   );

   for (genvar i = 0; i < int'(NUM_WIN); i++) begin : g_split
      assign out_wins[i] = acts[i];
      assign in_wins[i]  = acts[int'(NUM_WIN) + i];
   end

   vpx_lookup #(.NUM_WIN(NUM_WIN), .INBOUND(1'b0)) u_look_out (
      .wins  (out_wins),
      .addr  (lk_addr),
      .hit   (o_hit),
      .xaddr (o_addr),
      .kind  (o_kind),
      .bus   (o_bus),
      .devfn (o_dfn)
   );

   vpx_lookup #(.NUM_WIN(NUM_WIN), .INBOUND(1'b1)) u_look_in (
      .wins  (in_wins),
      .addr  (lk_addr),
      .hit   (i_hit),
      .xaddr (i_addr),
      .kind  (i_kind),
      .bus   (i_bus),
      .devfn (i_dfn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_addr  <= '0;
         res_kind  <= '0;
         res_bus   <= '0;
         res_devfn <= '0;
      end else begin
         res_valid <= lk_req;
         if (lk_req) begin
            res_hit   <= lk_inbound ? i_hit  : o_hit;
            res_addr  <= lk_inbound ? i_addr : o_addr;
            res_kind  <= lk_inbound ? i_kind : o_kind;
            res_bus   <= lk_inbound ? i_bus  : o_bus;
            res_devfn <= lk_inbound ? i_dfn  : o_dfn;
         end
      end
   end

   // R5
   res_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> res_valid);

   // R7
   miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> ((res_addr == $past(lk_addr)) && (res_kind == '0)));

   // R8
   cfg_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !kind_is_cfg(res_kind)) |-> ((res_bus == '0) && (res_devfn == '0)));

   // R9
   inb_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_hit && $past(lk_inbound)) |-> !kind_is_cfg(res_kind));
endmodule

// File: tb/tb_vpx_xlate.sv
module tb_vpx_xlate;
   localparam int CLK_PERIOD = 10;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lk_req = 1'b0;
   logic        lk_inbound = 1'b0;
   logic [63:0] lk_addr = '0;
   logic        res_valid, res_hit;
   logic [63:0] res_addr;
   logic [4:0]  res_kind;
   logic [7:0]  res_bus, res_devfn;

   vpx_xlate #(.NUM_WIN(N)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req),
      .lk_inbound(lk_inbound), .lk_addr(lk_addr), .res_valid(res_valid),
      .res_hit(res_hit), .res_addr(res_addr), .res_kind(res_kind),
      .res_bus(res_bus), .res_devfn(res_devfn)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model state
   logic [31:0] m_c1 [2*N];
   logic [31:0] m_c2 [2*N];
   logic [31:0] m_lim [2*N];
   logic [63:0] m_base [2*N];
   logic [63:0] m_tgt [2*N];
   logic        a_en [2*N];
   logic [4:0]  a_kind [2*N];
   logic [63:0] a_base [2*N];
   logic [31:0] a_lim [2*N];
   logic [63:0] a_tgt [2*N];
   logic        m_dir;
   logic [3:0]  m_idx;
   logic        e_valid, e_hit;
   logic [63:0] e_addr;
   logic [4:0]  e_kind;
   logic [7:0]  e_bus, e_devfn;

   int    checks = 0;
   int    fails = 0;
   bit    started = 0;
   string cur_req = "R10";

   task automatic m_reset();
      for (int s = 0; s < 2*N; s++) begin
         m_c1[s] = '0; m_c2[s] = '0; m_lim[s] = '0; m_base[s] = '0; m_tgt[s] = '0;
         a_en[s] = 1'b0; a_kind[s] = '0; a_base[s] = '0; a_lim[s] = '0; a_tgt[s] = '0;
      end
      // R10 default inbound pass-through window
      m_c2[N] = 32'h8000_0000; m_lim[N] = 32'hFFFF_FFFF;
      a_en[N] = 1'b1; a_lim[N] = 32'hFFFF_FFFF;
      m_dir = 1'b0; m_idx = '0;
      e_valid = 1'b0; e_hit = 1'b0; e_addr = '0; e_kind = '0; e_bus = '0; e_devfn = '0;
   endtask

   task automatic m_lookup(input logic inb, input logic [63:0] a);
      e_hit = 1'b0; e_addr = a; e_kind = '0; e_bus = '0; e_devfn = '0;
      for (int i = 0; i < N; i++) begin
         int s;
         logic [63:0] hi;
         logic cfg;
         s = (inb ? N : 0) + i;
         hi = {a_base[s][63:32], a_lim[s]};
         cfg = (a_kind[s] == 5'd4) || (a_kind[s] == 5'd5);
         if (!e_hit && a_en[s] && !(inb && cfg) && (a >= a_base[s]) && (a <= hi)) begin
            e_hit = 1'b1;
            e_addr = a - a_base[s] + a_tgt[s];
            e_kind = a_kind[s];
            if (cfg) begin
               e_bus = a_tgt[s][31:24];
               e_devfn = a_tgt[s][23:16];
            end
         end
      end
   endtask

   task automatic m_write(input logic [11:0] ad, input logic [31:0] d);
      int s;
      s = (m_dir ? N : 0) + int'(m_idx);
      if (ad == 12'h900) begin
         m_dir = d[31]; m_idx = d[3:0];
      end else if (int'(m_idx) < N) begin
         case (ad)
            12'h904: m_c1[s] = d;
            12'h908: begin
               m_c2[s] = d;
               if (d[31]) begin
                  a_en[s] = 1'b1; a_kind[s] = m_c1[s][4:0]; a_base[s] = m_base[s];
                  a_lim[s] = m_lim[s]; a_tgt[s] = m_tgt[s];
               end else a_en[s] = 1'b0;
            end
            12'h90C: m_base[s][31:0] = d;
            12'h910: m_base[s][63:32] = d;
            12'h914: m_lim[s] = d;
            12'h918: m_tgt[s][31:0] = d;
            12'h91C: m_tgt[s][63:32] = d;
            default: ;
         endcase
      end
   endtask

   function automatic logic [31:0] m_read(input logic [11:0] ad);
      int s;
      s = (m_dir ? N : 0) + int'(m_idx);
      if (ad == 12'h900) return {m_dir, 27'b0, m_idx};
      if (int'(m_idx) >= N) return '0;
      case (ad)
         12'h904: return m_c1[s];
         12'h908: return m_c2[s];
         12'h90C: return m_base[s][31:0];
         12'h910: return m_base[s][63:32];
         12'h914: return m_lim[s];
         12'h918: return m_tgt[s][31:0];
         12'h91C: return m_tgt[s][63:32];
         default: return '0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else begin
         e_valid = lk_req;
         if (lk_req) m_lookup(lk_inbound, lk_addr);
         if (reg_wr_en) m_write(reg_addr, reg_wdata);
      end
   end

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && started) begin
         chk(reg_rdata === m_read(reg_addr), "reg_rdata", 64'(reg_rdata), 64'(m_read(reg_addr)));
         chk(res_valid === e_valid, "res_valid", 64'(res_valid), 64'(e_valid));
         if (e_valid) begin
            chk(res_hit === e_hit, "res_hit", 64'(res_hit), 64'(e_hit));
            chk(res_addr === e_addr, "res_addr", res_addr, e_addr);
            chk(res_kind === e_kind, "res_kind", 64'(res_kind), 64'(e_kind));
            chk(res_bus === e_bus, "res_bus", 64'(res_bus), 64'(e_bus));
            chk(res_devfn === e_devfn, "res_devfn", 64'(res_devfn), 64'(e_devfn));
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a);
      reg_addr = a;
      @(posedge clk); #1;
   endtask

   task automatic look(input logic inb, input logic [63:0] a);
      lk_req = 1'b1; lk_inbound = inb; lk_addr = a;
      @(posedge clk); #1;
      lk_req = 1'b0;
   endtask

   task automatic prog(input logic [31:0] view, input logic [31:0] kind, input logic [63:0] base,
                       input logic [31:0] lim, input logic [63:0] tgt);
      wr(12'h900, view); wr(12'h904, kind);
      wr(12'h90C, base[31:0]); wr(12'h910, base[63:32]); wr(12'h914, lim);
      wr(12'h918, tgt[31:0]); wr(12'h91C, tgt[63:32]);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1; rst_n = 1'b1; started = 1;
      // R10 reset state and default inbound window
      cur_req = "R10";
      rd(12'h900); rd(12'h908);
      look(1'b1, 64'h0000_0000_1234_5678);
      look(1'b1, 64'h0000_0000_FFFF_FFFF);
      wr(12'h900, 32'h8000_0000); rd(12'h908); rd(12'h914); rd(12'h904);
      // R7 misses
      cur_req = "R7";
      look(1'b1, 64'h0000_0001_0000_0000);
      look(1'b0, 64'h0000_0000_0000_0055);
      // R1 selector fields
      cur_req = "R1";
      wr(12'h900, 32'h0000_0001); rd(12'h900);
      wr(12'h900, 32'h8000_0003); rd(12'h900);
      wr(12'h900, 32'h7FF0_0002); rd(12'h900);
      // R2 program outbound window 1
      cur_req = "R2";
      prog(32'h0000_0001, 32'h0, 64'h0000_0001_4000_0000, 32'h4000_FFFF, 64'h0000_0000_8000_0000);
      // R4 staged values not yet live
      cur_req = "R4";
      look(1'b0, 64'h0000_0001_4000_0010);
      cur_req = "R2";
      wr(12'h908, 32'hC000_0000);
      for (int k = 0; k < 8; k++) rd(12'h900 + 12'(4*k));
      rd(12'h920);
      // R5 range edges
      cur_req = "R5";
      look(1'b0, 64'h0000_0001_4000_0000);
      look(1'b0, 64'h0000_0001_4000_FFFF);
      look(1'b0, 64'h0000_0001_4001_0000);
      look(1'b0, 64'h0000_0001_3FFF_FFFF);
      // R4 commit semantics
      cur_req = "R4";
      wr(12'h918, 32'h9000_0000);
      look(1'b0, 64'h0000_0001_4000_0004);
      rd(12'h918);
      reg_wr_en = 1'b1; reg_addr = 12'h908; reg_wdata = 32'h8000_0000;
      lk_req = 1'b1; lk_inbound = 1'b0; lk_addr = 64'h0000_0001_4000_0008;
      @(posedge clk); #1;
      reg_wr_en = 1'b0; lk_req = 1'b0;
      look(1'b0, 64'h0000_0001_4000_0004);
      wr(12'h908, 32'h0);
      look(1'b0, 64'h0000_0001_4000_0004);
      wr(12'h908, 32'h8000_0000);
      look(1'b0, 64'h0000_0001_4000_0004);
      // R6 priority between overlapping windows
      cur_req = "R6";
      prog(32'h0000_0000, 32'h0, 64'h0000_0001_4000_0000, 32'h4000_00FF, 64'h0000_0002_0000_0000);
      wr(12'h908, 32'h8000_0000);
      prog(32'h0000_0002, 32'h0, 64'h0000_0001_4000_0000, 32'h4000_0FFF, 64'h0000_0003_0000_0000);
      wr(12'h908, 32'h8000_0000);
      look(1'b0, 64'h0000_0001_4000_0010);
      look(1'b0, 64'h0000_0001_4000_0200);
      wr(12'h900, 32'h0000_0001); wr(12'h908, 32'h0);
      look(1'b0, 64'h0000_0001_4000_0200);
      wr(12'h900, 32'h0000_0000); wr(12'h908, 32'h0);
      look(1'b0, 64'h0000_0001_4000_0010);
      // R8 configuration windows
      cur_req = "R8";
      prog(32'h0000_0003, 32'h4, 64'h0000_0000_E000_0000, 32'hE00F_FFFF, 64'h0000_0000_0305_0000);
      wr(12'h908, 32'h8000_0000);
      look(1'b0, 64'h0000_0000_E000_0100);
      wr(12'h904, 32'h5); wr(12'h918, 32'h1A28_0000); wr(12'h908, 32'h8000_0000);
      look(1'b0, 64'h0000_0000_E00F_FFFF);
      wr(12'h904, 32'h2); wr(12'h908, 32'h8000_0000);
      look(1'b0, 64'h0000_0000_E000_0040);
      // R9 inbound configuration window ignored
      cur_req = "R9";
      prog(32'h8000_0001, 32'h4, 64'h0, 32'h0000_FFFF, 64'h0000_0000_0100_0000);
      wr(12'h908, 32'h8000_0000);
      look(1'b1, 64'h0000_0000_0000_0100);
      wr(12'h900, 32'h8000_0000); wr(12'h908, 32'h0);
      look(1'b1, 64'h0000_0000_0000_0100);
      // R11 direction separation
      cur_req = "R11";
      look(1'b0, 64'h0000_0000_E000_0100);
      look(1'b1, 64'h0000_0000_E000_0100);
      prog(32'h8000_0002, 32'h0, 64'h0000_0000_2000_0000, 32'h2FFF_FFFF, 64'h0000_0007_0000_0000);
      wr(12'h908, 32'h8000_0000);
      look(1'b0, 64'h0000_0000_2000_0010);
      look(1'b1, 64'h0000_0000_2000_0010);
      // R3 out-of-range index
      cur_req = "R3";
      wr(12'h900, 32'h0000_0005);
      for (int k = 1; k < 8; k++) rd(12'h900 + 12'(4*k));
      wr(12'h90C, 32'hAAAA_0000); wr(12'h908, 32'h8000_0000); rd(12'h90C);
      wr(12'h900, 32'h8000_000F); wr(12'h914, 32'h1234_5678); rd(12'h914);
      wr(12'h900, 32'h0000_0001); rd(12'h90C); rd(12'h908);
      wr(12'h900, 32'h8000_0002); rd(12'h914);
      look(1'b0, 64'h0000_0001_4000_0000);
      look(1'b1, 64'h0000_0000_2000_0000);
      rd(12'h900);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule